// File: doc/BRIEF.md
# SPI Burst Transfer Master

This block is an SPI master that moves bursts of 16-bit words to or from a small window of registers in a peripheral. A host hands it one request at a time: a direction flag, a byte address, a byte count and, for writes, the words to send. The block forms a 16-bit command word, frames the whole exchange with an active-low chip select, shifts the command out in SPI mode 0, and then streams the data words out or captures them in.

The command word carries the direction in its top bit, a 3-bit register index taken from byte-address bits 4:2, and the length in 16-bit words in its low 12 bits. Odd byte counts are padded up to a whole word. Host words are packed in stream order: the earlier byte sits in bits 15:8. The wire wants each byte pair in the reverse order, so the block swaps the two bytes of every data word in both directions.

The SPI clock comes from a divider. It is derived at elaboration from the system clock and the requested rate, and clamped so the bus rate stays between 1 MHz and 52 MHz. Every step of a transaction is counted in half-periods of that divided clock, so the whole frame is fixed by the request alone.

Top module: `spi_burst_master`

## Requirements
- R1: Command bit 15 (the first bit on the wire) is 1 for a read request and 0 for a write request.
- R2: Command bits 14:12 equal bits 4:2 of the request address. All other address bits have no effect on the frame.
- R3: Command bits 11:0 hold ceil(byte count / 2), the number of 16-bit data words. All bits go out most significant bit first.
- R4: After the command, exactly ceil(byte count / 2) data words of 16 bits each are clocked, so an odd byte count moves one padding byte.
- R5: The bytes of each data word are swapped. A host write word H goes on the wire as {H[7:0], H[15:8]}. A wire word W received on a read is returned as {W[7:0], W[15:8]}.
- R6: SPI mode 0. The clock idles low, the slave samples on the rising edge, and MOSI changes only while the clock is low.
- R7: Chip select falls on the edge that accepts the request. The first rising clock edge comes one full SPI period later. Chip select rises half a period after the last falling edge and then stays high for at least one full period before the next frame.
- R8: Each SPI clock half-period lasts HALF system cycles. HALF = ceil(SYS_HZ / (2·F)), where F is the requested rate clamped to 1..52 MHz, and HALF is capped so the rate never falls below 1 MHz. At 250 MHz with 60 MHz requested, HALF is 3.
- R9: `busy` rises on the accepting edge and falls one full period after chip select rises. `req_ready` is its inverse, and a request presented while busy is ignored.
- R10: In a read, MOSI is held low for the whole data phase. `rd_valid` pulses for one cycle on the falling edge that ends each data word, with the corrected word on `rd_word`.
- R11: In a write, `wr_take` is high for one cycle just before each falling edge that ends the command or a data word that is followed by another word. The word on `wr_word` in that cycle is sent next. Reads never raise `wr_take`.
- R12: A byte count of zero produces a frame with only the 16 command bits and no data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Byte address; bits 4:2 select the register |
| req_bytes | input | BYTES_W (13) | Transfer length in bytes |
| wr_word | input | 16 | Next write word, earlier byte in bits 15:8 |
| wr_take | output | 1 | `wr_word` is consumed at this edge |
| rd_word | output | 16 | Received word after byte correction |
| rd_valid | output | 1 | `rd_word` is new this cycle |
| busy | output | 1 | Transaction in progress |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Master data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Slave data in |

## Verification
All timing is counted from the edge that accepts a request, in ticks of HALF cycles. Tick j lands k = j·HALF cycles after acceptance. With N = 16·(1 + words) bits in the frame:
- the clock is high for even j from 2 to 2N;
- chip select is low while j ≤ 2N+1;
- `busy` is high while j ≤ 2N+3;
- `rd_valid` is due at k = (3+2b)·HALF for the last bit b of each data word;
- `wr_take` is due one cycle earlier than that falling edge.

The bench compares these expected levels on every clock, sampling at the falling system-clock edge, half a cycle after the registers update. A slave model captures MOSI on each observed rising SPI edge and changes MISO only on observed falling edges. The captured frame is then compared field by field.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
  localparam int HDR_W   = 16;
  localparam int IDX_W   = 3;
  localparam int LEN_W   = HDR_W - 1 - IDX_W;
  localparam int BYTES_W = LEN_W + 1;
  localparam int WORD_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_TAIL, ST_GAP
  } st_t;

  // exchange the two bytes of a word (host stream order <-> wire order)
  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/spibm_tick.sv
module spibm_tick #(
  parameter int HALF = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  generate
    if (HALF > 1) begin : g_spacing
      // R8: half-period ticks never come on adjacent cycles
      a_r8_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/spibm_header.sv
module spibm_header
  import spibm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTES_W-1:0] nbytes,
  output logic [HDR_W-1:0]   hdr,
  output logic [LEN_W-1:0]   nwords
);
  logic [BYTES_W:0] padded;
  logic             unused_bits;

  assign padded      = {1'b0, nbytes} + 1'b1;
  assign nwords      = padded[LEN_W:1];
  assign hdr         = {rd, addr[4:2], nwords};
  assign unused_bits = ^{addr, padded};

  generate
    if (ADDR_W < 5) begin : g_bad_addr
      $error("address must be at least 5 bits wide");
    end
  endgenerate
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spibm_pkg::*;
#(
  parameter int SYS_HZ  = 250_000_000,
  parameter int SCLK_HZ = 25_000_000,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_read,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic [WORD_W-1:0]  wr_word,
  output logic               wr_take,
  output logic [WORD_W-1:0]  rd_word,
  output logic               rd_valid,
  output logic               busy,
  output logic               spi_sclk,
  output logic               spi_mosi,
  output logic               spi_cs_n,
  input  logic               spi_miso
);
  localparam int F_LO     = 1_000_000;
  localparam int F_HI     = 52_000_000;
  localparam int SCLK_EFF = (SCLK_HZ > F_HI) ? F_HI : ((SCLK_HZ < F_LO) ? F_LO : SCLK_HZ);
  localparam int HALF_UP  = (SYS_HZ + 2 * SCLK_EFF - 1) / (2 * SCLK_EFF);
  localparam int HALF_MAX = SYS_HZ / (2 * F_LO);
  localparam int HALF     = (HALF_UP > HALF_MAX) ? HALF_MAX : HALF_UP;

  generate
    if (HALF < 1 || (SYS_HZ / (2 * HALF)) > F_HI) begin : g_bad_div
      $error("no divider keeps the SPI clock within 1..52 MHz");
    end
  endgenerate

  st_t               st;
  logic              tick;
  logic [HDR_W-1:0]  hdr;
  logic [LEN_W-1:0]  hdr_words;
  logic [WORD_W-1:0] tx_sr, rx_sr, wr_wire;
  logic [3:0]        bit_idx;
  logic [LEN_W-1:0]  words_left;
  logic              rd_mode, in_hdr, gap_half;
  logic              word_end;
  logic              unused_tx;

  spibm_tick #(.HALF(HALF)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (st != ST_IDLE),
    .tick(tick)
  );

  spibm_header #(.ADDR_W(ADDR_W)) u_hdr (
    .rd    (req_read),
    .addr  (req_addr),
    .nbytes(req_bytes),
    .hdr   (hdr),
    .nwords(hdr_words)
  );

  assign wr_wire   = swap_bytes(wr_word);
  assign word_end  = (st == ST_HIGH) && tick && (bit_idx == 4'd15);
  assign wr_take   = word_end && (words_left != '0) && !rd_mode;
  assign req_ready = !busy;
  assign unused_tx = tx_sr[15];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      spi_cs_n   <= 1'b1;
      spi_sclk   <= 1'b0;
      spi_mosi   <= 1'b0;
      busy       <= 1'b0;
      rd_valid   <= 1'b0;
      rd_word    <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      bit_idx    <= '0;
      words_left <= '0;
      rd_mode    <= 1'b0;
      in_hdr     <= 1'b0;
      gap_half   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          st         <= ST_LEAD;
          busy       <= 1'b1;
          spi_cs_n   <= 1'b0;
          rd_mode    <= req_read;
          in_hdr     <= 1'b1;
          tx_sr      <= hdr;
          spi_mosi   <= hdr[HDR_W-1];
          words_left <= hdr_words;
          bit_idx    <= '0;
        end
        ST_LEAD: if (tick) st <= ST_LOW;
        ST_LOW: if (tick) begin
          spi_sclk <= 1'b1;
          rx_sr    <= {rx_sr[WORD_W-2:0], spi_miso};
          st       <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          spi_sclk <= 1'b0;
          if (bit_idx == 4'd15) begin
            bit_idx <= '0;
            if (rd_mode && !in_hdr) begin
              rd_valid <= 1'b1;
              rd_word  <= swap_bytes(rx_sr);
            end
            if (words_left == '0) begin
              st       <= ST_TAIL;
              spi_mosi <= 1'b0;
            end else begin
              words_left <= words_left - 1'b1;
              in_hdr     <= 1'b0;
              st         <= ST_LOW;
              if (rd_mode) begin
                tx_sr    <= '0;
                spi_mosi <= 1'b0;
              end else begin
                tx_sr    <= wr_wire;
                spi_mosi <= wr_wire[WORD_W-1];
              end
            end
          end else begin
            bit_idx  <= bit_idx + 1'b1;
            tx_sr    <= {tx_sr[WORD_W-2:0], 1'b0};
            spi_mosi <= tx_sr[WORD_W-2];
            st       <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) begin
          spi_cs_n <= 1'b1;
          gap_half <= 1'b0;
          st       <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_half) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end else begin
            gap_half <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: data only moves while the clock is low
  a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  // R7: no clock activity outside a frame
  a_r7_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  // R9: busy covers the whole framed interval
  a_r9_busy_spans_frame: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);
  // R9: an accepted request opens a frame at once
  a_r9_accept_opens: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && !spi_cs_n && !spi_sclk));
  // R10: read strobe lasts one cycle, on a falling edge inside the frame
  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  a_r10_strobe_in_frame: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!spi_cs_n && !spi_sclk));
  // R11: write words are only pulled during a write, with the clock high
  a_r11_take_write_only: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (!rd_mode && !spi_cs_n && spi_sclk));
endmodule

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  import spibm_pkg::*;

  // R8: 250 MHz system clock, 60 MHz requested -> clamp to 52 MHz -> ceil(250/104) = 3
  localparam int HALF = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic               req_read = 1'b0;
  logic [7:0]         req_addr = '0;
  logic [BYTES_W-1:0] req_bytes = '0;
  logic [15:0]        wr_word = '0;
  logic               wr_take;
  logic [15:0]        rd_word;
  logic               rd_valid;
  logic               busy;
  logic               spi_sclk, spi_mosi, spi_cs_n;
  logic               spi_miso = 1'b0;

  always #2 clk = ~clk;

  spi_burst_master #(.SYS_HZ(250_000_000), .SCLK_HZ(60_000_000), .ADDR_W(8)) u_spi_burst_master (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_addr(req_addr), .req_bytes(req_bytes),
    .wr_word(wr_word), .wr_take(wr_take),
    .rd_word(rd_word), .rd_valid(rd_valid), .busy(busy),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  // expectations for the frame in flight
  bit          x_rd;
  int          x_words;
  logic [15:0] x_hdr;
  bit          x_bits[$];
  logic [15:0] x_rdq[$];
  bit          s_bits[$];
  logic [15:0] hq[$];

  // per-clock timing model
  bit m_act = 0, m_pend = 0, p_rd = 0;
  int m_k = 0, m_n = 0, p_bytes = 0;

  always @(negedge clk) begin
    int j, n2, b, jj;
    bit e_cs_n, e_sclk, e_busy, e_rd, e_take;
    if (!rst) begin
      if (m_pend) begin
        m_act = 1; m_k = 0; m_n = 16 * (1 + (p_bytes + 1) / 2); m_pend = 0;
      end else if (m_act) m_k++;
      j  = m_k / HALF;
      n2 = 2 * m_n;
      e_cs_n = !(m_act && j <= n2 + 1);
      e_sclk = m_act && j >= 2 && j <= n2 && (j % 2 == 0);
      e_busy = m_act && j <= n2 + 3;
      e_rd = 0;
      if (m_act && p_rd && (m_k % HALF == 0) && (j % 2 == 1) && j >= 3 && j <= n2 + 1) begin
        b = (j - 3) / 2;
        e_rd = (b % 16 == 15) && b >= 31;
      end
      e_take = 0;
      if (m_act && !p_rd && ((m_k + 1) % HALF == 0)) begin
        jj = (m_k + 1) / HALF;
        if (jj % 2 == 1 && jj >= 3) begin
          b = (jj - 3) / 2;
          e_take = (b % 16 == 15) && (b < m_n - 16);
        end
      end
      chk(spi_sclk == e_sclk, "R8", "sclk level", spi_sclk, e_sclk);
      chk(spi_cs_n == e_cs_n, "R7", "cs_n level", spi_cs_n, e_cs_n);
      chk(busy == e_busy, "R9", "busy level", busy, e_busy);
      chk(req_ready == !e_busy, "R9", "ready level", req_ready, !e_busy);
      chk(rd_valid == e_rd, "R10", "rd_valid timing", rd_valid, e_rd);
      chk(wr_take == e_take, "R11", "wr_take timing", wr_take, e_take);
      if (m_act && !e_busy) m_act = 0;
      if (req_valid && !e_busy) begin
        m_pend = 1; p_rd = req_read; p_bytes = int'(req_bytes);
      end
    end
  end

  // slave model and frame checking
  bit pv_sclk = 0, pv_cs = 1;
  bit cap[$];
  int takes = 0;
  int frames = 0;

  function automatic bit next_miso();
    if (s_bits.size() > 0) return s_bits.pop_front();
    return 1'b0;
  endfunction

  function automatic void frame_check();
    logic [15:0] g, gw, ew;
    int nb = cap.size();
    chk(nb == x_bits.size(), (x_words == 0) ? "R12" : "R4", "frame bit count", nb, x_bits.size());
    if (nb >= 16) begin
      g = '0;
      for (int i = 0; i < 16; i++) g = {g[14:0], cap[i]};
      chk(g[15] == x_hdr[15], "R1", "read flag", g[15], x_hdr[15]);
      chk(g[14:12] == x_hdr[14:12], "R2", "register index", g[14:12], x_hdr[14:12]);
      chk(g[11:0] == x_hdr[11:0], "R3", "word count field", g[11:0], x_hdr[11:0]);
    end
    for (int w = 0; w < x_words; w++) begin
      if (nb >= 16 * (w + 2) && x_bits.size() >= 16 * (w + 2)) begin
        gw = '0; ew = '0;
        for (int i = 0; i < 16; i++) begin
          gw = {gw[14:0], cap[16 * (w + 1) + i]};
          ew = {ew[14:0], x_bits[16 * (w + 1) + i]};
        end
        chk(gw == ew, x_rd ? "R10" : "R5", "data word on MOSI", gw, ew);
      end
    end
    chk(takes == (x_rd ? 0 : x_words), "R11", "write words taken", takes, x_rd ? 0 : x_words);
    chk(x_rdq.size() == 0, "R10", "read words not delivered", x_rdq.size(), 0);
    cap.delete();
    takes = 0;
  endfunction

  always @(negedge clk) begin
    logic [15:0] ex;
    if (!rst) begin
      if (wr_take) takes++;
      if (!spi_cs_n && pv_cs) spi_miso = next_miso();
      if (!spi_cs_n && spi_sclk && !pv_sclk) cap.push_back(spi_mosi);
      if (!spi_cs_n && !spi_sclk && pv_sclk) spi_miso = next_miso();
      if (rd_valid) begin
        ex = (x_rdq.size() > 0) ? x_rdq.pop_front() : 16'hDEAD;
        chk(rd_word == ex, "R5", "read word byte order", rd_word, ex);
      end
      if (spi_cs_n && !pv_cs) begin
        frame_check();
        frames++;
      end
      pv_sclk = spi_sclk;
      pv_cs   = spi_cs_n;
    end
  end

  // host write-word supply: advance after each consumption
  bit tk_pend = 0;
  always @(negedge clk) begin
    if (tk_pend) begin
      wr_word = (hq.size() > 0) ? hq.pop_front() : 16'h0000;
      tk_pend = 0;
    end
    if (wr_take) tk_pend = 1;
  end

  task automatic run_txn(bit rd, logic [7:0] addr, int nbytes, bit poke);
    int w = (nbytes + 1) / 2;
    int f0;
    logic [15:0] wire_w, h;
    x_hdr = {rd, addr[4:2], 12'(w)};
    x_bits.delete(); s_bits.delete(); x_rdq.delete(); hq.delete();
    for (int i = 15; i >= 0; i--) x_bits.push_back(x_hdr[i]);
    for (int i = 0; i < 16; i++) s_bits.push_back(bit'(i % 2));
    for (int i = 0; i < w; i++) begin
      if (rd) begin
        wire_w = 16'(16'h1357 + i * 16'h2468);
        for (int q = 15; q >= 0; q--) begin
          s_bits.push_back(wire_w[q]);
          x_bits.push_back(1'b0);
        end
        x_rdq.push_back({wire_w[7:0], wire_w[15:8]});
      end else begin
        h = 16'hA1B2 ^ 16'(i * 16'h1111) ^ {addr, addr};
        hq.push_back(h);
        wire_w = {h[7:0], h[15:8]};
        for (int q = 15; q >= 0; q--) x_bits.push_back(wire_w[q]);
      end
    end
    x_rd = rd;
    x_words = w;
    if (!rd && hq.size() > 0) wr_word = hq.pop_front();
    f0 = frames;
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1; req_read = rd; req_addr = addr; req_bytes = BYTES_W'(nbytes);
    @(posedge clk); #1;
    req_valid = 0;
    if (poke) begin
      // R9: a competing request while busy must leave the frame untouched
      repeat (2) @(posedge clk); #1;
      req_valid = 1; req_read = !rd; req_addr = ~addr; req_bytes = BYTES_W'(40);
      repeat (8) @(posedge clk); #1;
      req_valid = 0;
    end
    wait (frames > f0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R7", "reset cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R6", "reset sclk", spi_sclk, 0);
    chk(busy == 1'b0, "R9", "reset busy", busy, 0);
    chk(rd_valid == 1'b0, "R10", "reset rd_valid", rd_valid, 0);
    run_txn(1'b0, 8'h14, 4, 1'b0);  // R1 R5 R11: write, index 5, two words
    run_txn(1'b1, 8'h08, 6, 1'b0);  // R1 R10: read, index 2, three words
    run_txn(1'b0, 8'hFF, 3, 1'b0);  // R2 R4: odd count padded, index 7
    run_txn(1'b1, 8'hE0, 1, 1'b0);  // R2 R4: upper address bits ignored
    run_txn(1'b0, 8'h1C, 0, 1'b0);  // R12: command only
    run_txn(1'b0, 8'h04, 2, 1'b1);  // R9: request while busy ignored
    run_txn(1'b1, 8'h10, 8, 1'b0);  // R3 R6 R7: back-to-back, four words
    repeat (20) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule